// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial byte memory. It watches the clock and data lines and finds the bus start and stop events. It takes in a slave address byte, two word address bytes and any data bytes, and it answers on the ninth clock of each byte by pulling the data line low through an open-drain style output. The block samples both lines on a fast system clock, so every bus event reaches the logic as a one-cycle strobe.

A write fills a page buffer. The low address bits step through the page and wrap inside it. A stop commits the buffered bytes to the array and starts a self-timed write cycle, whose length is a parameter counted in system clock cycles. While that cycle runs, the block ignores the bus completely, so a master can poll the address byte until the block acknowledges again.

A read returns bytes in order, most significant bit first, starting from an internal address counter. The counter runs through the whole array and wraps to zero at the end. If a stop follows the word address bytes, the block only loads the address counter, which sets up a later current-address read.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the block leaves the data line released (`sda_low_o` = 0), and it ignores the bus until it sees a start.
- R2: A start is data falling while clock is high, and a stop is data rising while clock is high. A start seen at any point, including partway through a byte, discards the partial byte and begins reception of a new slave address byte.
- R3: The slave address byte is acknowledged only when bits 7:4 equal 1010 and bits 3:1 equal `sel_i`. Bit 0 selects the direction, with 1 meaning read. On any mismatch the block gives no acknowledge and ignores every later byte until the next start.
- R4: In write direction the block acknowledges the high word address byte, then the low word address byte, then every data byte. The high byte supplies the address bits above bit 7, and bits beyond the array width are ignored.
- R5: Data bytes of a write go to consecutive offsets within one page, where the offset is the low PAGE_W address bits. The offset wraps from the last slot of the page to the first, and a later byte sent to the same slot replaces an earlier one.
- R6: A stop after at least one data byte commits the page and starts a write cycle of WRITE_CYCLES clocks. During that cycle the block never drives the data line, so its address byte goes unacknowledged.
- R7: Once the write cycle ends, the block acknowledges its address again, and the committed bytes read back unchanged.
- R8: In read direction the block drives eight bits, most significant first, and then samples the master's acknowledge. On an acknowledge it sends the byte at the next address, and the address wraps from the top of the array to 0.
- R9: When the master does not acknowledge a read byte, the block releases the data line and drives nothing until the next start or stop.
- R10: A stop that comes directly after the low word address byte loads the address counter and starts no write cycle. The next current-address read returns the byte at that address.
- R11: A start that arrives after data bytes have been buffered, where a stop would normally end the write, throws the buffered bytes away. No write cycle follows and the array keeps its old contents.
- R12: After a write the address counter holds the last written address plus one, wrapping within the page. A current-address read returns the byte at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| sel_i | input | 3 | Select pins compared with slave address bits 3:1 |
| sda_low_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench builds the block with ADDR_W = 8, PAGE_W = 3 and WRITE_CYCLES = 400. This gives a 256-byte array with 8-byte pages. A ten-byte write therefore laps its page and overwrites the first two slots, and a sequential read started at 0xFE crosses the top of the array back to 0 after a handful of bytes. With 400 cycles, the write cycle still covers the ninth clock of a poll that starts right after the stop, so the missing acknowledge can be seen. A wait of a little over 400 cycles is enough to see the acknowledge come back.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_ACK,
    ST_RDAT,
    ST_RACK,
    ST_WAITSTOP
  } twi_state_e;

  localparam logic [3:0] TYPE_CODE = 4'b1010;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_lvl
);

  localparam int LINES = 2;

  logic [LINES-1:0]                  raw;
  logic [LINES-1:0][SYNC_STAGES-1:0] chain;
  logic [LINES-1:0]                  prev;
  logic                              scl_s, sda_s, scl_p, sda_p;

  assign raw   = {sda_i, scl_i};
  assign scl_s = chain[0][SYNC_STAGES-1];
  assign sda_s = chain[1][SYNC_STAGES-1];
  assign scl_p = prev[0];
  assign sda_p = prev[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= '1;
    end else begin
      for (int l = 0; l < LINES; l++) begin
        chain[l] <= {chain[l][SYNC_STAGES-2:0], raw[l]};
        prev[l]  <= chain[l][SYNC_STAGES-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
      sda_lvl   <= 1'b1;
    end else begin
      scl_rise  <= scl_s & ~scl_p;
      scl_fall  <= ~scl_s & scl_p;
      start_det <= scl_s & scl_p & sda_p & ~sda_s;
      stop_det  <= scl_s & scl_p & ~sda_p & sda_s;
      sda_lvl   <= sda_s;
    end
  end

endmodule

// File: rtl/twi_busy_timer.sv
module twi_busy_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  output logic busy
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (launch) begin
      remain <= CW'(CYCLES);
    end else if (remain != '0) begin
      remain <= remain - CW'(1);
    end
  end

  assign busy = (remain != '0);

endmodule

// File: rtl/twi_page_buffer.sv
module twi_page_buffer #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [PAGE_W-1:0]        wr_idx,
  input  logic [7:0]               wr_data,
  input  logic                     clear,
  input  logic                     commit,
  input  logic [ADDR_W-PAGE_W-1:0] page_base,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_waddr,
  output logic [7:0]               mem_wdata
);

  localparam int SLOTS = 1 << PAGE_W;

  logic [7:0]               slot [SLOTS];
  logic [SLOTS-1:0]         filled;
  logic                     active;
  logic [PAGE_W-1:0]        cidx;
  logic [ADDR_W-PAGE_W-1:0] base_q;
  logic                     last_slot;

  assign last_slot = active && (cidx == PAGE_W'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filled    <= '0;
      active    <= 1'b0;
      cidx      <= '0;
      base_q    <= '0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (commit) begin
        active <= 1'b1;
        cidx   <= '0;
        base_q <= page_base;
      end else if (active) begin
        mem_we    <= filled[cidx];
        mem_waddr <= {base_q, cidx};
        mem_wdata <= slot[cidx];
        cidx      <= cidx + PAGE_W'(1);
        if (last_slot) active <= 1'b0;
      end
      if (clear || last_slot) begin
        filled <= '0;
      end else if (wr_en) begin
        filled[wr_idx] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 2000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] sel_i,
  output logic       sda_low_o
);

  localparam int SLOTS       = 1 << PAGE_W;
  localparam int BUSY_CYCLES = (WRITE_CYCLES > SLOTS + 2) ? WRITE_CYCLES : SLOTS + 2;
  localparam int BASE_W      = ADDR_W - PAGE_W;

  logic scl_rise, scl_fall, start_det, stop_det, sda_lvl;
  logic busy;

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_lvl)
  );

  twi_state_e        state, after_ack;
  logic [2:0]        bit_cnt;
  logic              byte_rdy;
  logic [7:0]        rx_sh;
  logic [6:0]        tx_rest;
  logic [7:0]        addr_hi;
  logic [ADDR_W-1:0] addr_cnt;
  logic              wr_pending;
  logic              acked;
  logic              sda_low;
  logic              launch;
  logic              buf_wr_en, buf_clear;
  logic [PAGE_W-1:0] buf_wr_idx;
  logic [7:0]        buf_wr_data;
  logic [BASE_W-1:0] commit_base;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata;
  logic [7:0]        rd_data;
  logic              dev_match;
  logic [ADDR_W-1:0] page_next;

  assign dev_match = (rx_sh[7:4] == TYPE_CODE) && (rx_sh[3:1] == sel_i);
  assign page_next = {addr_cnt[ADDR_W-1:PAGE_W], addr_cnt[PAGE_W-1:0] + PAGE_W'(1)};
  assign sda_low_o = sda_low;

  twi_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .launch(launch), .busy(busy)
  );

  twi_page_buffer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst(rst),
    .wr_en(buf_wr_en), .wr_idx(buf_wr_idx), .wr_data(buf_wr_data),
    .clear(buf_clear), .commit(launch), .page_base(commit_base),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  twi_mem_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(addr_cnt), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      after_ack   <= ST_IDLE;
      bit_cnt     <= '0;
      byte_rdy    <= 1'b0;
      rx_sh       <= '0;
      tx_rest     <= '0;
      addr_hi     <= '0;
      addr_cnt    <= '0;
      wr_pending  <= 1'b0;
      acked       <= 1'b0;
      sda_low     <= 1'b0;
      launch      <= 1'b0;
      buf_wr_en   <= 1'b0;
      buf_clear   <= 1'b0;
      buf_wr_idx  <= '0;
      buf_wr_data <= '0;
      commit_base <= '0;
    end else begin
      launch    <= 1'b0;
      buf_wr_en <= 1'b0;
      buf_clear <= 1'b0;
      if (busy) begin
        state   <= ST_IDLE;
        sda_low <= 1'b0;
      end else if (start_det) begin
        state    <= ST_DEV;
        bit_cnt  <= '0;
        byte_rdy <= 1'b0;
        sda_low  <= 1'b0;
        if (wr_pending) begin
          buf_clear  <= 1'b1;
          wr_pending <= 1'b0;
        end
      end else if (stop_det) begin
        state   <= ST_IDLE;
        sda_low <= 1'b0;
        if (wr_pending) begin
          launch      <= 1'b1;
          commit_base <= addr_cnt[ADDR_W-1:PAGE_W];
          wr_pending  <= 1'b0;
        end
      end else begin
        case (state)
          ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[6:0], sda_lvl};
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) byte_rdy <= 1'b1;
            end else if (scl_fall && byte_rdy) begin
              byte_rdy <= 1'b0;
              bit_cnt  <= '0;
              case (state)
                ST_DEV: begin
                  if (dev_match) begin
                    sda_low   <= 1'b1;
                    state     <= ST_ACK;
                    after_ack <= rx_sh[0] ? ST_RDAT : ST_AHI;
                  end else begin
                    state <= ST_WAITSTOP;
                  end
                end
                ST_AHI: begin
                  addr_hi   <= rx_sh;
                  sda_low   <= 1'b1;
                  state     <= ST_ACK;
                  after_ack <= ST_ALO;
                end
                ST_ALO: begin
                  addr_cnt  <= ADDR_W'({addr_hi, rx_sh});
                  sda_low   <= 1'b1;
                  state     <= ST_ACK;
                  after_ack <= ST_WDAT;
                end
                default: begin
                  buf_wr_en   <= 1'b1;
                  buf_wr_idx  <= addr_cnt[PAGE_W-1:0];
                  buf_wr_data <= rx_sh;
                  addr_cnt    <= page_next;
                  wr_pending  <= 1'b1;
                  sda_low     <= 1'b1;
                  state       <= ST_ACK;
                  after_ack   <= ST_WDAT;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state   <= after_ack;
              bit_cnt <= '0;
              if (after_ack == ST_RDAT) begin
                tx_rest  <= rd_data[6:0];
                sda_low  <= ~rd_data[7];
                addr_cnt <= addr_cnt + ADDR_W'(1);
              end else begin
                sda_low <= 1'b0;
              end
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              if (bit_cnt == 3'd7) begin
                sda_low <= 1'b0;
                state   <= ST_RACK;
              end else begin
                bit_cnt <= bit_cnt + 3'd1;
                sda_low <= ~tx_rest[6];
                tx_rest <= {tx_rest[5:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              acked <= ~sda_lvl;
            end else if (scl_fall) begin
              if (acked) begin
                state    <= ST_RDAT;
                bit_cnt  <= '0;
                tx_rest  <= rd_data[6:0];
                sda_low  <= ~rd_data[7];
                addr_cnt <= addr_cnt + ADDR_W'(1);
              end else begin
                state <= ST_WAITSTOP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk
  import twi_mem_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_low,
  input logic       busy,
  input logic       mem_we,
  input twi_state_e state
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !sda_low); // R1

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_low); // R2

  AST_IGNORED_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAITSTOP) |-> !sda_low); // R3

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_low); // R6

  AST_WRITE_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy); // R6

  AST_DRIVE_CLOCK_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low) |-> !scl_i); // R8

endmodule

bind twi_mem_slave twi_mem_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_low(sda_low_o),
  .busy(busy), .mem_we(mem_we), .state(state)
);

// File: tb/twi_mem_slave_tb.sv
module twi_mem_slave_tb;

  localparam int AW = 8;
  localparam int PW = 3;
  localparam int WC = 400;
  localparam int Q  = 6;
  localparam logic [2:0] SEL  = 3'b101;
  localparam logic [7:0] DEVW = {4'b1010, SEL, 1'b0};
  localparam logic [7:0] DEVR = {4'b1010, SEL, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_low;
  wire  sda_bus = sda_m & ~sda_low;

  always #2 clk = ~clk;

  twi_mem_slave #(.ADDR_W(AW), .PAGE_W(PW), .WRITE_CYCLES(WC)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .sel_i(SEL), .sda_low_o(sda_low)
  );

  int n_chk  = 0;
  int n_fail = 0;

  typedef struct {
    logic [7:0] val;
    string      req;
  } exp_t;
  exp_t       exp_q[$];
  event       rd_ev;
  logic [7:0] rd_val;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(rd_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected byte", int'(rd_val), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rd_val === e.val, e.req, int'(rd_val), int'(e.val));
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic s);
    sda_m = b;
    wt(Q);
    scl_m = 1'b1;
    wt(Q);
    s = sda_bus;
    wt(Q);
    scl_m = 1'b0;
    wt(Q);
  endtask

  task automatic m_start;
    sda_m = 1'b1;
    wt(Q);
    scl_m = 1'b1;
    wt(Q);
    sda_m = 1'b0;
    wt(Q);
    scl_m = 1'b0;
    wt(Q);
  endtask

  task automatic m_stop;
    sda_m = 1'b0;
    wt(Q);
    scl_m = 1'b1;
    wt(Q);
    sda_m = 1'b1;
    wt(Q);
  endtask

  task automatic send(input logic [7:0] d, input logic exp_ack, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], s);
    bus_bit(1'b1, s);
    check(~s == exp_ack, req, int'(~s), int'(exp_ack));
  endtask

  task automatic recv(input logic give_ack, input logic [7:0] exp_v, input string req);
    logic s;
    logic [7:0] d;
    exp_t e;
    e.val = exp_v;
    e.req = req;
    exp_q.push_back(e);
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      d[i] = s;
    end
    bus_bit(~give_ack, s);
    rd_val = d;
    ->rd_ev;
  endtask

  task automatic write_bytes(input logic [7:0] a, input logic [7:0] base, input int n, input string req);
    m_start;
    send(DEVW, 1'b1, req);
    send(8'h00, 1'b1, req);
    send(a, 1'b1, req);
    for (int i = 0; i < n; i++) send(base + 8'(i), 1'b1, req);
    m_stop;
  endtask

  task automatic set_addr_read(input logic [7:0] a, input string req);
    m_start;
    send(DEVW, 1'b1, req);
    send(8'h00, 1'b1, req);
    send(a, 1'b1, req);
    m_start;
    send(DEVR, 1'b1, req);
  endtask

  initial begin
    wt(150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1-R12 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic s;
    wt(5);
    rst = 1'b0;
    wt(5);
    // R1: released after reset
    check(sda_low == 1'b0, "R1 reset release", int'(sda_low), 0);

    // R2: start partway through a byte restarts address reception
    m_start;
    for (int i = 0; i < 4; i++) bus_bit(i[0], s);
    m_start;
    send(DEVW, 1'b1, "R2 restart ack");
    m_stop;

    // R3: select mismatch and type mismatch
    m_start;
    send({4'b1010, 3'b100, 1'b0}, 1'b0, "R3 select nack");
    send(8'h5A, 1'b0, "R3 ignored byte");
    m_stop;
    m_start;
    send({4'b1011, SEL, 1'b0}, 1'b0, "R3 type nack");
    m_stop;

    // R4: byte acks on write, then R6 poll during write cycle
    write_bytes(8'h10, 8'hA0, 4, "R4 write ack");
    m_start;
    send(DEVW, 1'b0, "R6 busy nack");
    m_stop;
    wt(WC + 50);

    // R7 / R8 / R9
    m_start;
    send(DEVW, 1'b1, "R7 ready ack");
    send(8'h00, 1'b1, "R7 addr ack");
    send(8'h10, 1'b1, "R7 addr ack");
    m_start;
    send(DEVR, 1'b1, "R8 read ack");
    recv(1'b1, 8'hA0, "R7 data 0");
    recv(1'b1, 8'hA1, "R8 seq 1");
    recv(1'b1, 8'hA2, "R8 seq 2");
    recv(1'b0, 8'hA3, "R8 seq 3");
    bus_bit(1'b1, s);
    check(s == 1'b1, "R9 released after nack", int'(s), 1);
    m_stop;

    // R5: ten bytes lap an eight-byte page
    write_bytes(8'h30, 8'hC0, 10, "R5 write ack");
    wt(WC + 50);

    // R12: counter after write points at last + 1 within page
    m_start;
    send(DEVR, 1'b1, "R12 read ack");
    recv(1'b0, 8'hC2, "R12 current read");
    m_stop;

    set_addr_read(8'h30, "R5 addr");
    recv(1'b1, 8'hC8, "R5 slot 0 overwritten");
    recv(1'b1, 8'hC9, "R5 slot 1 overwritten");
    for (int i = 2; i < 8; i++) recv(i != 7, 8'hC0 + 8'(i), "R5 slot kept");
    m_stop;

    // R10: address-only load
    m_start;
    send(DEVW, 1'b1, "R10 ack");
    send(8'h00, 1'b1, "R10 ack");
    send(8'h33, 1'b1, "R10 ack");
    m_stop;
    m_start;
    send(DEVR, 1'b1, "R10 no write cycle");
    recv(1'b0, 8'hC3, "R10 current read");
    m_stop;

    // R11: start after buffered data discards it
    m_start;
    send(DEVW, 1'b1, "R11 ack");
    send(8'h00, 1'b1, "R11 ack");
    send(8'h30, 1'b1, "R11 ack");
    send(8'h77, 1'b1, "R11 data ack");
    set_addr_read(8'h30, "R11 not busy");
    recv(1'b0, 8'hC8, "R11 old data kept");
    m_stop;

    // R8: array wrap during sequential read
    write_bytes(8'hFE, 8'hE0, 2, "R8 write top");
    wt(WC + 50);
    write_bytes(8'h00, 8'hF0, 2, "R8 write bottom");
    wt(WC + 50);
    set_addr_read(8'hFE, "R8 addr");
    recv(1'b1, 8'hE0, "R8 top 0");
    recv(1'b1, 8'hE1, "R8 top 1");
    recv(1'b1, 8'hF0, "R8 wrap 0");
    recv(1'b0, 8'hF1, "R8 wrap 1");
    m_stop;

    wt(20);
    check(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
    check(sda_low == 1'b0, "R2 idle after stop", int'(sda_low), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule